// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block remembers the destinations of branches that have been taken, so that the decode stage can steer instruction fetch before a branch is resolved. The decode stage presents the linear address of a branch instruction. In the same cycle the buffer reports whether it holds that branch, the target address it stores, and a taken or not-taken guess. The guess comes from a two-bit saturating history kept with each entry. A branch that is not in the buffer is always guessed not-taken.

Later in the pipeline, a resolve port reports the real outcome of each branch. It gives the branch address, whether the branch was taken, the real target, and a flag that says the predicted target was wrong. A taken branch that is not yet in the buffer gets an entry, with its history set to the strongest taken state. A branch that is already in the buffer has its history moved one step toward its real outcome. The stored target is rewritten only when the entry is created, or when a taken branch reports a wrong target.

The buffer has 64 sets of 4 ways, 256 entries in all. Each set chooses which entry to replace with a three-bit tree of recently used ways.

Top module: `btb`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any address misses.
- R2: A lookup hits when a valid entry in set `addr[5:0]` holds tag `addr[31:6]`. On a hit the block outputs that entry's target and predicts taken when the history is in a taken state. On a miss it predicts not-taken and outputs a target of zero. The lookup result is available in the same cycle as the address.
- R3: History uses the encoding 2'b11 strongly taken, 2'b10 weakly taken, 2'b01 weakly not-taken and 2'b00 strongly not-taken. The upper bit is the prediction. A resolve that hits moves the history one step up if the branch was taken and one step down if it was not, saturating at 2'b11 and at 2'b00.
- R4: Starting from a strong state, the prediction changes polarity only after two consecutive opposite outcomes.
- R5: A resolve that misses with the branch taken allocates an entry. The entry holds the tag, the resolved target, and history 2'b11.
- R6: A resolve that misses with the branch not taken changes nothing, so a later lookup of that address still misses.
- R7: On a resolve hit, the target is rewritten only when the branch was taken and the mispredict flag is set. In every other case the target is kept, and the tag is never rewritten on a hit.
- R8: On allocation the victim is the lowest-numbered invalid way of the set. If every way is valid, the victim comes from the set's tree bits {b2,b1,b0}: b0=0 selects way 0 or 1 by b1, and b0=1 selects way 2 or 3 by b2.
- R9: An allocation or a resolve hit marks its way as used. Ways 0 and 1 set b0=1, ways 2 and 3 clear b0. Way 0 sets b1 and way 1 clears it. Way 2 sets b2 and way 3 clears it. The next tree victim in that set is therefore never the way just marked.
- R10: A lookup changes no state. A lookup in the same cycle as a resolve sees the contents from before the resolve, and at most one way of a set can match an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Linear address of the branch being decoded |
| lk_hit | output | 1 | Lookup address found in the buffer |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_target | output | 32 | Predicted target address, zero on a miss |
| rs_valid | input | 1 | A branch is being resolved this cycle |
| rs_addr | input | 32 | Linear address of the resolved branch |
| rs_taken | input | 1 | Actual direction of the resolved branch |
| rs_target | input | 32 | Actual target of the resolved branch |
| rs_mispredict | input | 1 | The predicted target of the resolved branch was wrong |

## Verification
The assertions that inspect the buffer's contents assume that, in the cycle after a resolve, the lookup address repeats the resolved address. They also assume that the resolve inputs are defined whenever `rs_valid` is high. The stimulus takes both lookup and resolve addresses from a small pool of set indices and tags. This makes back-to-back repeats of an address, full sets and evictions common, and every resolve drives all of its fields. The mispredict flag is driven freely and is not tied to the stored target, because the block uses it only as a write permission.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int NWAY  = 4;
    localparam int WAY_W = 2;

    typedef enum logic [1:0] {
        HIST_SNT = 2'b00,
        HIST_WNT = 2'b01,
        HIST_WT  = 2'b10,
        HIST_ST  = 2'b11
    } hist_e;

    // saturating one-step move toward the observed outcome
    function automatic hist_e hist_next(input hist_e h, input logic taken);
        hist_e r;
        r = h;
        if (taken) begin
            if (h != HIST_ST) r = hist_e'(h + 2'd1);
        end else begin
            if (h != HIST_SNT) r = hist_e'(h - 2'd1);
        end
        return r;
    endfunction

    function automatic logic hist_pred(input hist_e h);
        return h[1];
    endfunction

    // tree bits {b2,b1,b0}
    function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] b);
        logic [WAY_W-1:0] w;
        if (!b[0]) w = b[1] ? 2'd1 : 2'd0;
        else       w = b[2] ? 2'd3 : 2'd2;
        return w;
    endfunction

    function automatic logic [2:0] plru_mark(input logic [2:0] b, input logic [WAY_W-1:0] w);
        logic [2:0] r;
        r = b;
        r[0] = (w < 2'd2);
        if (w < 2'd2) r[1] = (w == 2'd0);
        else          r[2] = (w == 2'd2);
        return r;
    endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way #(
    parameter int SETS  = 64,
    parameter int TAG_W = 26,
    parameter int TGT_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    // lookup read port
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    output logic [TGT_W-1:0] a_tgt,
    output logic [1:0]       a_hist,
    // resolve read port
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    output logic             b_valid,
    output logic [TGT_W-1:0] b_tgt,
    output logic [1:0]       b_hist,
    // write port
    input  logic [IDX_W-1:0] w_idx,
    input  logic             w_alloc,
    input  logic [TAG_W-1:0] w_tag,
    input  logic             w_tgt_en,
    input  logic [TGT_W-1:0] w_tgt,
    input  logic             w_hist_en,
    input  logic [1:0]       w_hist
);

    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [TGT_W-1:0] tgt_q  [SETS];
    logic [1:0]       hist_q [SETS];

    always_ff @(posedge clk) begin
        if (rst)          valid_q <= '0;
        else if (w_alloc) valid_q[w_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (w_alloc)   tag_q[w_idx]  <= w_tag;
        if (w_tgt_en)  tgt_q[w_idx]  <= w_tgt;
        if (w_hist_en) hist_q[w_idx] <= w_hist;
    end

    always_comb begin
        a_hit   = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
        a_tgt   = tgt_q[a_idx];
        a_hist  = hist_q[a_idx];
        b_valid = valid_q[b_idx];
        b_hit   = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
        b_tgt   = tgt_q[b_idx];
        b_hist  = hist_q[b_idx];
    end

    // R5: an allocation leaves its entry valid in the next cycle
    a_r5_alloc_valid: assert property (@(posedge clk) disable iff (rst)
        w_alloc ##1 (b_idx == $past(w_idx)) |-> b_valid);

endmodule

// File: rtl/btb_plru.sv
module btb_plru #(
    parameter int SETS = 64,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          q_idx,
    output logic [btb_pkg::WAY_W-1:0] q_victim,
    input  logic                      t_en,
    input  logic [IDX_W-1:0]          t_idx,
    input  logic [btb_pkg::WAY_W-1:0] t_way
);
    import btb_pkg::*;

    logic [2:0] bits_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= 3'b000;
        end else if (t_en) begin
            bits_q[t_idx] <= plru_mark(bits_q[t_idx], t_way);
        end
    end

    assign q_victim = plru_pick(bits_q[q_idx]);

    // R9: the way just marked is not the next tree victim of that set
    a_r9_victim_moves: assert property (@(posedge clk) disable iff (rst)
        t_en ##1 (q_idx == $past(t_idx)) |-> (q_victim != $past(t_way)));

endmodule

// File: rtl/btb.sv
module btb #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 32,
    parameter int SETS   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [TGT_W-1:0]  lk_target,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    input  logic [TGT_W-1:0]  rs_target,
    input  logic              rs_mispredict
);
    import btb_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;

    assign lk_idx = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
    assign rs_idx = rs_addr[IDX_W-1:0];
    assign rs_tag = rs_addr[ADDR_W-1:IDX_W];

    logic [NWAY-1:0]  lk_hv, rs_hv, rs_vv;
    logic [TGT_W-1:0] lk_tv [NWAY];
    logic [TGT_W-1:0] rs_tv [NWAY];
    logic [1:0]       lk_hs [NWAY];
    logic [1:0]       rs_hs [NWAY];

    logic             rs_hit_any, alloc, inv_any;
    logic [WAY_W-1:0] rs_hit_way, inv_way, tree_way, alloc_way;
    logic [TGT_W-1:0] rs_tgt_cur;
    hist_e            rs_hist_cur;

    // resolve-side decode
    always_comb begin
        rs_hit_any  = 1'b0;
        rs_hit_way  = '0;
        rs_tgt_cur  = '0;
        rs_hist_cur = HIST_SNT;
        inv_any     = 1'b0;
        inv_way     = '0;
        for (int w = NWAY - 1; w >= 0; w--) begin
            if (rs_hv[w]) begin
                rs_hit_any  = 1'b1;
                rs_hit_way  = WAY_W'(w);
                rs_tgt_cur  = rs_tv[w];
                rs_hist_cur = hist_e'(rs_hs[w]);
            end
            if (!rs_vv[w]) begin
                inv_any = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
    end

    assign alloc     = rs_valid && !rs_hit_any && rs_taken;
    assign alloc_way = inv_any ? inv_way : tree_way;

    generate
        for (genvar g = 0; g < NWAY; g++) begin : g_way
            logic       w_alloc, w_tgt_en, w_hist_en;
            logic [1:0] w_hist;

            always_comb begin
                w_alloc   = alloc && (alloc_way == WAY_W'(g));
                w_tgt_en  = w_alloc || (rs_valid && rs_hv[g] && rs_taken && rs_mispredict);
                w_hist_en = w_alloc || (rs_valid && rs_hv[g]);
                w_hist    = w_alloc ? HIST_ST : hist_next(hist_e'(rs_hs[g]), rs_taken);
            end

            btb_way #(.SETS(SETS), .TAG_W(TAG_W), .TGT_W(TGT_W)) way_i (
                .clk      (clk),
                .rst      (rst),
                .a_idx    (lk_idx),
                .a_tag    (lk_tag),
                .a_hit    (lk_hv[g]),
                .a_tgt    (lk_tv[g]),
                .a_hist   (lk_hs[g]),
                .b_idx    (rs_idx),
                .b_tag    (rs_tag),
                .b_hit    (rs_hv[g]),
                .b_valid  (rs_vv[g]),
                .b_tgt    (rs_tv[g]),
                .b_hist   (rs_hs[g]),
                .w_idx    (rs_idx),
                .w_alloc  (w_alloc),
                .w_tag    (rs_tag),
                .w_tgt_en (w_tgt_en),
                .w_tgt    (rs_target),
                .w_hist_en(w_hist_en),
                .w_hist   (w_hist)
            );
        end
    endgenerate

    btb_plru #(.SETS(SETS)) plru_i (
        .clk     (clk),
        .rst     (rst),
        .q_idx   (rs_idx),
        .q_victim(tree_way),
        .t_en    (alloc || (rs_valid && rs_hit_any)),
        .t_idx   (rs_idx),
        .t_way   (alloc ? alloc_way : rs_hit_way)
    );

    // lookup-side selection
    always_comb begin
        lk_hit    = 1'b0;
        lk_taken  = 1'b0;
        lk_target = '0;
        for (int w = 0; w < NWAY; w++) begin
            if (lk_hv[w]) begin
                lk_hit    = 1'b1;
                lk_taken  = hist_pred(hist_e'(lk_hs[w]));
                lk_target = lk_tv[w];
            end
        end
    end

    // R1: the cycle after reset sees no hit
    a_r1_reset_miss: assert property (@(posedge clk)
        rst |=> !lk_hit);

    // R10: at most one way matches on either port
    a_r10_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hv) && $onehot0(rs_hv));

    // R5: a taken miss is found next cycle, predicted taken, with its target
    a_r5_alloc_visible: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit_any && rs_taken) ##1 (lk_addr == $past(rs_addr))
        |-> (lk_hit && lk_taken && lk_target == $past(rs_target)));

    // R6: a not-taken miss leaves the address absent
    a_r6_no_alloc: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit_any && !rs_taken) ##1 (lk_addr == $past(rs_addr))
        |-> !lk_hit);

    // R7: target kept unless taken with mispredict
    a_r7_target_kept: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit_any && !(rs_taken && rs_mispredict)) ##1 (lk_addr == $past(rs_addr))
        |-> (lk_hit && lk_target == $past(rs_tgt_cur)));

    // R3: a taken outcome from any state above strongly not-taken predicts taken next
    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit_any && rs_taken && rs_hist_cur != HIST_SNT) ##1 (lk_addr == $past(rs_addr))
        |-> lk_taken);

    // R3: a not-taken outcome from weakly taken or below predicts not-taken next
    a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_hit_any && !rs_taken && rs_hist_cur != HIST_ST) ##1 (lk_addr == $past(rs_addr))
        |-> (lk_hit && !lk_taken));

endmodule

// File: tb/btb_tb_top.sv
`timescale 1ns/1ps
module btb_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_addr = '0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_addr = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;
    logic        rs_mispredict = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    btb dut_i (
        .clk(clk), .rst(rst),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
        .rs_target(rs_target), .rs_mispredict(rs_mispredict)
    );

    // behavioural reference
    bit          m_v [4][64];
    bit [25:0]   m_tag [4][64];
    bit [31:0]   m_t [4][64];
    bit [1:0]    m_h [4][64];
    bit [2:0]    m_p [64];

    function automatic int m_find(input bit [31:0] a);
        int r = -1;
        for (int w = 0; w < 4; w++)
            if (m_v[w][a[5:0]] && m_tag[w][a[5:0]] == a[31:6]) r = w;
        return r;
    endfunction

    task automatic m_reset();
        for (int s = 0; s < 64; s++) begin
            m_p[s] = 3'b000;
            for (int w = 0; w < 4; w++) m_v[w][s] = 1'b0;
        end
    endtask

    task automatic m_mark(input int s, input int w);
        m_p[s][0] = (w < 2);
        if (w < 2) m_p[s][1] = (w == 0);
        else       m_p[s][2] = (w == 2);
    endtask

    task automatic m_update(input bit rv, input bit [31:0] ra, input bit rt,
                            input bit [31:0] rtg, input bit rm);
        int s, h, vw;
        if (!rv) return;
        s = int'(ra[5:0]);
        h = m_find(ra);
        if (h >= 0) begin
            if (rt && m_h[h][s] != 2'b11) m_h[h][s] = m_h[h][s] + 2'd1;
            if (!rt && m_h[h][s] != 2'b00) m_h[h][s] = m_h[h][s] - 2'd1;
            if (rt && rm) m_t[h][s] = rtg;
            m_mark(s, h);
        end else if (rt) begin
            vw = -1;
            for (int w = 3; w >= 0; w--) if (!m_v[w][s]) vw = w;
            if (vw < 0) begin
                if (!m_p[s][0]) vw = m_p[s][1] ? 1 : 0;
                else            vw = m_p[s][2] ? 3 : 2;
            end
            m_v[vw][s] = 1'b1;
            m_tag[vw][s] = ra[31:6];
            m_t[vw][s] = rtg;
            m_h[vw][s] = 2'b11;
            m_mark(s, vw);
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare combinational lookup, model update at edge
    task automatic cyc(input bit [31:0] la, input bit rv, input bit [31:0] ra, input bit rt,
                       input bit [31:0] rtg, input bit rm,
                       input bit ex, input bit eh, input bit et, input bit [31:0] etg,
                       input string req);
        int h;
        bit xh, xt;
        bit [31:0] xtg;
        lk_addr = la; rs_valid = rv; rs_addr = ra; rs_taken = rt;
        rs_target = rtg; rs_mispredict = rm;
        #1;
        h = m_find(la);
        xh = (h >= 0);
        xt = xh ? m_h[h][la[5:0]][1] : 1'b0;
        xtg = xh ? m_t[h][la[5:0]] : 32'h0;
        // model comparison every cycle (R2 R10)
        check(lk_hit == xh, "R2", "model hit", {31'b0, lk_hit}, {31'b0, xh});
        check(lk_taken == xt, "R2", "model taken", {31'b0, lk_taken}, {31'b0, xt});
        check(lk_target == xtg, "R10", "model target", lk_target, xtg);
        if (ex) begin
            check(lk_hit == eh, req, "hit", {31'b0, lk_hit}, {31'b0, eh});
            check(lk_taken == et, req, "taken", {31'b0, lk_taken}, {31'b0, et});
            check(lk_target == etg, req, "target", lk_target, etg);
        end
        @(posedge clk);
        m_update(rv, ra, rt, rtg, rm);
        @(negedge clk);
    endtask

    task automatic probe(input bit [31:0] a, input bit eh, input bit et,
                         input bit [31:0] etg, input string req);
        cyc(a, 0, 0, 0, 0, 0, 1, eh, et, etg, req);
    endtask

    task automatic res(input bit [31:0] ra, input bit rt, input bit [31:0] rtg, input bit rm);
        cyc(32'h0, 1, ra, rt, rtg, rm, 0, 0, 0, 0, "");
    endtask

    function automatic bit [31:0] A(input int tag, input int set);
        return (32'(tag) << 6) | 32'(set);
    endfunction

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    fails++;
                    checks++;
                    $display("FAIL watchdog actual=expired expected=finished");
                    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                    $finish;
                end
            end
        join_none

        m_reset();
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset
        probe(A(1, 5), 0, 0, 32'h0, "R1");
        probe(A(7, 63), 0, 0, 32'h0, "R1");

        // R5: taken miss allocates in strongly taken
        res(A(1, 5), 1, 32'h1000, 1);
        probe(A(1, 5), 1, 1, 32'h1000, "R5");

        // R3/R4: history walk
        res(A(1, 5), 0, 32'h0, 1);
        probe(A(1, 5), 1, 1, 32'h1000, "R4");    // weakly taken, still taken
        res(A(1, 5), 0, 32'h0, 1);
        probe(A(1, 5), 1, 0, 32'h1000, "R4");    // weakly not-taken, flipped
        res(A(1, 5), 0, 32'h0, 0);
        res(A(1, 5), 0, 32'h0, 0);               // saturates at strongly not-taken
        res(A(1, 5), 1, 32'h1000, 1);
        probe(A(1, 5), 1, 0, 32'h1000, "R3");    // one step up only
        res(A(1, 5), 1, 32'h1000, 1);
        probe(A(1, 5), 1, 1, 32'h1000, "R3");

        // R7: target rewrite rules
        res(A(1, 5), 1, 32'h2000, 1);
        probe(A(1, 5), 1, 1, 32'h2000, "R7");
        res(A(1, 5), 1, 32'h3000, 0);
        probe(A(1, 5), 1, 1, 32'h2000, "R7");
        res(A(1, 5), 0, 32'h4000, 1);
        probe(A(1, 5), 1, 1, 32'h2000, "R7");

        // R6: not-taken miss does not allocate
        res(A(9, 5), 0, 32'h5000, 1);
        probe(A(9, 5), 0, 0, 32'h0, "R6");

        // R8: fill set 5, lowest invalid way first, then tree victim (way 0)
        res(A(2, 5), 1, 32'h2200, 1);
        res(A(3, 5), 1, 32'h3300, 1);
        res(A(4, 5), 1, 32'h4400, 1);
        probe(A(1, 5), 1, 1, 32'h2000, "R8");
        probe(A(4, 5), 1, 1, 32'h4400, "R8");
        res(A(5, 5), 1, 32'h5500, 1);
        probe(A(1, 5), 0, 0, 32'h0, "R8");
        probe(A(5, 5), 1, 1, 32'h5500, "R8");

        // R9: marking way 0 moves the victim to way 2 (A3)
        res(A(6, 5), 1, 32'h6600, 1);
        probe(A(3, 5), 0, 0, 32'h0, "R9");
        probe(A(2, 5), 1, 1, 32'h2200, "R9");
        probe(A(6, 5), 1, 1, 32'h6600, "R9");

        // R10: same-cycle lookup sees old contents
        cyc(A(6, 5), 1, A(6, 5), 1, 32'h7700, 1, 1, 1, 1, 32'h6600, "R10");
        probe(A(6, 5), 1, 1, 32'h7700, "R10");
        cyc(A(8, 5), 1, A(8, 5), 1, 32'h8800, 1, 1, 0, 0, 32'h0, "R10");
        probe(A(8, 5), 1, 1, 32'h8800, "R10");

        // mixed traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] a, b;
            int sel;
            sel = $urandom_range(0, 4);
            a = A($urandom_range(0, 7), (sel == 4) ? 63 : sel);
            sel = $urandom_range(0, 4);
            b = A($urandom_range(0, 7), (sel == 4) ? 63 : sel);
            if ($urandom_range(0, 2) == 0) b = a;
            cyc(($urandom_range(0, 1) == 0) ? b : a,
                $urandom_range(0, 3) != 0, a, $urandom_range(0, 2) != 0,
                $urandom, $urandom_range(0, 1), 0, 0, 0, 0, "");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule